// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block sits between a processor core and a data memory whose port is one word wide. The core hands it a byte address, an access kind and, for stores, a data register value. The unit turns this into a word address, a set of byte write enables and store data moved onto the byte lanes that the address selects. For loads, it takes the word the memory returns, picks out the addressed byte, halfword or word, and widens it to a full word with sign or zero fill. Base-plus-offset address arithmetic happens upstream, and the storage array lives outside.

Both data paths use valid/ready handshakes. A request passes straight through to the memory request channel, so the memory's ready is the core's ready. The memory's response comes back through a load-result channel whose ready is passed back to the memory. At most one load is in flight, because the unit keeps the lane offset and kind of that one load until its data returns. The memory must hold its response valid and data steady until the unit takes them. The core must hold a request steady until it is accepted. Word accesses must be 4-byte aligned and halfword accesses 2-byte aligned. A misaligned access gives undefined data and lanes. It also sets a sticky debug flag.

Top module: `lsu_lane_unit`

## Requirements
- R1: The word address sent to memory is the byte address shifted right by two. The two dropped bits are the lane offset. Memory is little-endian, so lane k is data bits 8k+7..8k.
- R2: Kind codes on `req_kind` are: 0 word load, 1 signed half load, 2 unsigned half load, 3 signed byte load, 4 unsigned byte load, 5 word store, 6 half store, 7 byte store. Write enable is high only for codes 5 to 7. A byte store enables one lane (the offset). A half store enables the two lanes starting at the even offset. A word store enables all four lanes. Every load enables all four lanes.
- R3: Store data appears on the enabled lanes. A byte store puts bits 7..0 of the data on the addressed lane. A half store puts bits 15..0 on lanes offset and offset+1. A word store puts the whole word unchanged.
- R4: A word load returns the memory word unchanged.
- R5: A byte load returns the lane at the offset in bits 7..0. The signed form copies bit 7 into bits 31..8, and the unsigned form fills them with zero.
- R6: A halfword load returns lanes offset+1 and offset in bits 15..0. The signed form copies bit 15 upward, and the unsigned form fills with zero.
- R7: With no load outstanding, `req_ready` equals `mem_req_ready`, and an accepted request is always also a memory request handshake.
- R8: Once a load is accepted, `req_ready` stays low until that load's result is taken on the result channel.
- R9: `ld_valid` is high only while a load is outstanding and the memory presents its response. `mem_rsp_ready` follows `ld_ready`. Under back-pressure the result stays stable.
- R10: `misalign_seen` rises after an accepted word access with a nonzero offset or a halfword access with an odd offset. It never rises for byte accesses. It stays high until reset.
- R11: After reset `misalign_seen` and `ld_valid` are low, and no load is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_kind | input | 3 | Access kind code (see R2) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data register value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_we | output | 1 | Memory write enable |
| mem_word_addr | output | ADDR_W-2 | Word address |
| mem_be | output | DATA_W/8 | Byte lane enables |
| mem_wdata | output | DATA_W | Lane-aligned store data |
| mem_rsp_valid | input | 1 | Memory read response valid |
| mem_rsp_ready | output | 1 | Unit takes the response |
| mem_rdata | input | DATA_W | Memory read word |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Core takes the load result |
| ld_data | output | DATA_W | Extended load result |
| misalign_seen | output | 1 | Sticky misaligned-access flag |

## Verification
The bench builds the unit with a 16-bit byte address and the default 32-bit data word. This gives a 14-bit word address. The behavioural memory decodes the low bits of that address, so every lane offset of sixteen words can be reached. The bench stalls the memory request ready and the result ready in a repeating pattern. This lets it test the one-outstanding-load rule and result stability while the result is held back, alongside the lane arithmetic for every size and offset. One access is deliberately misaligned to raise the sticky flag. Its returned data is not compared.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [2:0] {
    K_LW  = 3'd0,
    K_LH  = 3'd1,
    K_LHU = 3'd2,
    K_LB  = 3'd3,
    K_LBU = 3'd4,
    K_SW  = 3'd5,
    K_SH  = 3'd6,
    K_SB  = 3'd7
  } acc_kind_e;

  function automatic logic kind_is_store(acc_kind_e k);
    return (k == K_SW) || (k == K_SH) || (k == K_SB);
  endfunction

  function automatic logic kind_is_byte(acc_kind_e k);
    return (k == K_LB) || (k == K_LBU) || (k == K_SB);
  endfunction

  function automatic logic kind_is_half(acc_kind_e k);
    return (k == K_LH) || (k == K_LHU) || (k == K_SH);
  endfunction
endpackage

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_kind_e          kind,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [DATA_W-1:0]  wdata,
  output logic [LANES-1:0]   be,
  output logic [DATA_W-1:0]  lane_data
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_IDX = OFS_W'(i);
    always_comb begin
      be[i] = 1'b1;
      lane_data[i*8 +: 8] = wdata[i*8 +: 8];
      if (kind_is_store(kind)) begin
        if (kind_is_byte(kind)) begin
          be[i] = (ofs == LANE_IDX);
          lane_data[i*8 +: 8] = wdata[7:0];
        end else if (kind_is_half(kind)) begin
          be[i] = (ofs[OFS_W-1:1] == LANE_IDX[OFS_W-1:1]);
          lane_data[i*8 +: 8] = wdata[(i%2)*8 +: 8];
        end
      end else begin
        lane_data[i*8 +: 8] = '0;
      end
    end
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  acc_kind_e          kind,
  input  logic [OFS_W-1:0]   ofs,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  result
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic [OFS_W+2:0] byte_pos;
  logic [OFS_W+2:0] half_pos;

  always_comb begin
    byte_pos = {ofs, 3'b000};
    half_pos = {ofs[OFS_W-1:1], 4'b0000};
    byte_sel = rdata[byte_pos +: 8];
    half_sel = rdata[half_pos +: 16];
    unique case (kind)
      K_LB:    result = {{(DATA_W-8){byte_sel[7]}}, byte_sel};
      K_LBU:   result = {{(DATA_W-8){1'b0}}, byte_sel};
      K_LH:    result = {{(DATA_W-16){half_sel[15]}}, half_sel};
      K_LHU:   result = {{(DATA_W-16){1'b0}}, half_sel};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lane_align_check.sv
module lane_align_check
  import lsu_lane_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_kind_e         kind,
  input  logic [OFS_W-1:0]  ofs,
  output logic              misaligned
);
  always_comb begin
    if (kind_is_byte(kind))      misaligned = 1'b0;
    else if (kind_is_half(kind)) misaligned = ofs[0];
    else                         misaligned = (ofs != '0);
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_we,
  output logic [ADDR_W-OFS_W-1:0] mem_word_addr,
  output logic [LANES-1:0]    mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                ld_valid,
  input  logic                ld_ready,
  output logic [DATA_W-1:0]   ld_data,
  output logic                misalign_seen
);
  acc_kind_e        kind_in;
  logic [OFS_W-1:0] ofs_in;
  logic             load_pending;
  acc_kind_e        pend_kind;
  logic [OFS_W-1:0] pend_ofs;
  logic             req_fire;
  logic             load_accept;
  logic             rsp_fire;
  logic             bad_align;

  assign kind_in = acc_kind_e'(req_kind);
  assign ofs_in  = req_addr[OFS_W-1:0];

  // Request channel: straight through, blocked while a load is in flight.
  assign mem_req_valid = req_valid && !load_pending;
  assign req_ready     = mem_req_ready && !load_pending;
  assign req_fire      = req_valid && req_ready;
  assign load_accept   = req_fire && !kind_is_store(kind_in);
  assign mem_we        = kind_is_store(kind_in);
  assign mem_word_addr = req_addr[ADDR_W-1:OFS_W];

  lane_store_pack #(.DATA_W(DATA_W)) u_pack (
    .kind      (kind_in),
    .ofs       (ofs_in),
    .wdata     (req_wdata),
    .be        (mem_be),
    .lane_data (mem_wdata)
  );

  lane_align_check #(.OFS_W(OFS_W)) u_align (
    .kind       (kind_in),
    .ofs        (ofs_in),
    .misaligned (bad_align)
  );

  // Response channel: passed through while the one load is outstanding.
  assign ld_valid      = load_pending && mem_rsp_valid;
  assign mem_rsp_ready = load_pending && ld_ready;
  assign rsp_fire      = ld_valid && ld_ready;

  lane_load_extract #(.DATA_W(DATA_W)) u_extract (
    .kind   (pend_kind),
    .ofs    (pend_ofs),
    .rdata  (mem_rdata),
    .result (ld_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_pending  <= 1'b0;
      pend_kind     <= K_LW;
      pend_ofs      <= '0;
      misalign_seen <= 1'b0;
    end else begin
      if (load_accept) begin
        load_pending <= 1'b1;
        pend_kind    <= kind_in;
        pend_ofs     <= ofs_in;
      end else if (rsp_fire) begin
        load_pending <= 1'b0;
      end
      if (req_fire && bad_align) misalign_seen <= 1'b1;
    end
  end

  // R2
  be_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && kind_in == K_SB) |-> ($countones(mem_be) == 1));
  // R2
  be_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && kind_in == K_SH) |-> ($countones(mem_be) == 2));
  // R2
  be_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_we) |-> (&mem_be));
  // R7
  issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (mem_req_valid && mem_req_ready));
  // R8
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_accept |=> !req_ready);
  // R9
  rsp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> mem_rsp_valid);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_seen |=> misalign_seen);
endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic mem_we;
  logic [AW-3:0] mem_word_addr;
  logic [3:0] mem_be;
  logic [DW-1:0] mem_wdata;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [DW-1:0] mem_rdata = '0;
  logic ld_valid;
  logic ld_ready = 1'b0;
  logic [DW-1:0] ld_data;
  logic misalign_seen;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit stall_ld = 1'b0;
  bit finished = 1'b0;

  logic [31:0] mem [16];
  logic [31:0] shadow [16];
  logic [31:0] exp_q [$];
  bit care_q [$];
  string tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_lane_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_we(mem_we), .mem_word_addr(mem_word_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_data(ld_data),
    .misalign_seen(misalign_seen)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Ready patterns change just after the rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= ((cyc % 3) != 2);
    ld_ready <= !stall_ld && ((cyc % 8) != 5);
  end

  // Behavioural memory.
  always @(posedge clk) begin
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_we) begin
        for (int l = 0; l < 4; l++)
          if (mem_be[l]) mem[mem_word_addr[3:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rdata <= mem[mem_word_addr[3:0]];
      end
    end
  end

  // Monitor: compare each taken load result against the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rst_n && ld_valid && ld_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", ld_data, 32'h0);
      end else begin
        logic [31:0] e;
        bit c;
        string t;
        e = exp_q.pop_front();
        c = care_q.pop_front();
        t = tag_q.pop_front();
        if (c) chk(ld_data == e, t, ld_data, e);
      end
    end
  end

  function automatic logic [31:0] exp_load(input logic [2:0] k, input logic [31:0] w, input logic [1:0] o);
    logic [7:0] b;
    logic [15:0] h;
    b = w[o*8 +: 8];
    h = w[o[1]*16 +: 16];
    case (k)
      3'd1: return {{16{h[15]}}, h};
      3'd2: return {16'h0, h};
      3'd3: return {{24{b[7]}}, b};
      3'd4: return {24'h0, b};
      default: return w;
    endcase
  endfunction

  function automatic string load_tag(input logic [2:0] k);
    if (k == 3'd0) return "R4 word load";
    if (k >= 3'd3) return "R5 byte load";
    return "R6 half load";
  endfunction

  task automatic issue(input logic [2:0] k, input logic [AW-1:0] a, input logic [31:0] d, input bit care);
    logic [1:0] o;
    logic [3:0] ebe;
    logic [31:0] ew;
    logic [31:0] mask;
    int idx;
    o = a[1:0];
    idx = int'(a[5:2]);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    chk(mem_req_valid && mem_req_ready, "R7 request handshake", {31'h0, mem_req_valid}, 32'h1);
    chk(mem_word_addr == a[AW-1:2], "R1 word address", 32'(mem_word_addr), 32'(a[AW-1:2]));
    if (k >= 3'd5) begin
      case (k)
        3'd7: begin ebe = 4'b0001 << o; ew = {4{d[7:0]}}; end
        3'd6: begin ebe = 4'b0011 << {o[1], 1'b0}; ew = {2{d[15:0]}}; end
        default: begin ebe = 4'b1111; ew = d; end
      endcase
      chk(mem_we && mem_be == ebe, "R2 store enables", {27'h0, mem_we, mem_be}, {28'h1, ebe});
      for (int l = 0; l < 4; l++) mask[l*8 +: 8] = {8{ebe[l]}};
      chk((mem_wdata & mask) == (ew & mask), "R3 store lanes", mem_wdata & mask, ew & mask);
      for (int l = 0; l < 4; l++) if (ebe[l]) shadow[idx][l*8 +: 8] = ew[l*8 +: 8];
    end else begin
      chk(!mem_we && mem_be == 4'hF, "R2 load enables", {27'h0, mem_we, mem_be}, 32'hF);
      exp_q.push_back(exp_load(k, shadow[idx], o));
      care_q.push_back(care);
      tag_q.push_back(load_tag(k));
    end
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results returned", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h8100_7F00 + i * 32'h0102_0304;
      shadow[i] = 32'h8100_7F00 + i * 32'h0102_0304;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(misalign_seen == 1'b0, "R11 flag after reset", {31'h0, misalign_seen}, 32'h0);
    chk(ld_valid == 1'b0, "R11 no result after reset", {31'h0, ld_valid}, 32'h0);
    rst_n = 1'b1;
    #1;
    chk(req_ready == mem_req_ready, "R11 R7 idle ready", {31'h0, req_ready}, {31'h0, mem_req_ready});

    for (int w = 0; w < 4; w++) issue(3'd5, AW'(w*4), 32'h80FF_017F ^ (w * 32'h1111_0000), 1'b1);
    for (int w = 0; w < 6; w++) issue(3'd0, AW'(w*4), 32'h0, 1'b1);
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o++) begin
        issue(3'd3, AW'(w*4+o), 32'h0, 1'b1);
        issue(3'd4, AW'(w*4+o), 32'h0, 1'b1);
      end
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o += 2) begin
        issue(3'd1, AW'(w*4+o), 32'h0, 1'b1);
        issue(3'd2, AW'(w*4+o), 32'h0, 1'b1);
      end
    for (int o = 0; o < 4; o++) issue(3'd7, AW'(20+o), 32'hDEAD_BE80 + 32'(o), 1'b1);
    issue(3'd6, AW'(24), 32'h1234_9ABC, 1'b1);
    issue(3'd6, AW'(26), 32'hFFFF_5678, 1'b1);
    issue(3'd7, AW'(16'h0120), 32'h0000_00C3, 1'b1);
    for (int o = 0; o < 4; o++) issue(3'd3, AW'(20+o), 32'h0, 1'b1);
    issue(3'd0, AW'(20), 32'h0, 1'b1);
    issue(3'd1, AW'(24), 32'h0, 1'b1);
    issue(3'd2, AW'(26), 32'h0, 1'b1);
    issue(3'd0, AW'(24), 32'h0, 1'b1);
    issue(3'd4, AW'(16'h0120), 32'h0, 1'b1);
    drain();
    chk(misalign_seen == 1'b0, "R10 no flag for legal accesses", {31'h0, misalign_seen}, 32'h0);

    // R8 / R9: hold the result back and watch the request side stay closed.
    stall_ld = 1'b1;
    repeat (2) @(posedge clk);
    issue(3'd1, AW'(6), 32'h0, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    begin
      logic [31:0] held;
      held = ld_data;
      chk(ld_valid == 1'b1, "R9 result offered", {31'h0, ld_valid}, 32'h1);
      chk(req_ready == 1'b0, "R8 busy while outstanding", {31'h0, req_ready}, 32'h0);
      chk(mem_rsp_ready == 1'b0, "R9 back-pressure passed", {31'h0, mem_rsp_ready}, 32'h0);
      repeat (3) @(negedge clk);
      #1;
      chk(ld_data == held, "R9 result stable", ld_data, held);
      chk(req_ready == 1'b0, "R8 still busy", {31'h0, req_ready}, 32'h0);
    end
    stall_ld = 1'b0;
    drain();

    // R10 sticky misalign flag.
    issue(3'd0, AW'(16'h0021), 32'h0, 1'b0);
    drain();
    @(negedge clk);
    chk(misalign_seen == 1'b1, "R10 flag raised", {31'h0, misalign_seen}, 32'h1);
    issue(3'd5, AW'(28), 32'h0BAD_F00D, 1'b1);
    issue(3'd0, AW'(28), 32'h0, 1'b1);
    drain();
    chk(misalign_seen == 1'b1, "R10 flag sticky", {31'h0, misalign_seen}, 32'h1);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule